// File: doc/BRIEF.md
# Motion Vector Output Formatter

This block turns reconstructed luma motion vectors and their field-reference bits into the words a motion compensation stage reads for each macroblock. For every macroblock it takes a short run of header words and then a run of luma vector components. Each component is formatted in one of two ways. Horizontal components are moved from a centre-referenced origin to an upper-left origin. Vertical components get the reference-field bit spliced in just above the half-pixel flag. From each luma component the block also derives a pair of chroma words, using a halving rule for horizontal components and a plain copy for vertical ones.

The words of each macroblock are assembled into one half of a double buffer while a downstream reader drains the other half through a valid/ready port. The writer accepts input only while it owns a free half. When both halves hold packets that are not yet fully read, the input port stalls. A half goes back to the writer only after the last word of its packet has been handed out.

The writer FSM has three states. WR_WAIT_FREE moves to WR_TAKE_HDR once the target half is free. WR_TAKE_HDR moves to WR_TAKE_VEC after the last header word is accepted. WR_TAKE_VEC commits the half and returns to WR_WAIT_FREE after the last vector is accepted. The reader FSM has two states. RD_IDLE moves to RD_SEND when the half it points at is full. RD_SEND returns to RD_IDLE when the last word of the packet is taken.

Top module: `mvfmt_top`

## Requirements
- R1: While reset is asserted, and at any time when no complete packet is stored, `out_valid` is 0. `in_ready` is 0 during reset and becomes 1 within two cycles after reset is released.
- R2: Each packet is 55 words, handed out in this order: the 7 header words in arrival order (index 0-6), then the 16 luma words in arrival order (index 7-22), then 32 chroma words. Luma input k produces chroma words at index 23+2k and 24+2k. `out_last` is 1 on index 54 only.
- R3: Vector inputs use the low 12 bits of `in_data` as a two's-complement value v. Within each group of four vector inputs, positions 0 and 2 are horizontal and positions 1 and 3 are vertical. A horizontal luma word equals v+16 when `hp_mode`=1 and v+8 when `hp_mode`=0, as a 16-bit two's-complement value. `in_ref` has no effect on horizontal words.
- R4: A vertical luma word carries v[0] at bit 0, `in_ref` at bit 1, and the arithmetic shift v>>>1, sign-extended, in bits 15:2.
- R5: Both chroma words from a horizontal input equal h+8 (`hp_mode`=1) or h+4 (`hp_mode`=0). Here h is v>>>1 with its bit 0 ORed with v[0].
- R6: Both chroma words from a vertical input are identical to that input's R4 luma word.
- R7: Two complete packets can be stored with no reads. While two stored packets are both unfinished, `in_ready` stays 0.
- R8: A buffer half is released only after all 55 of its words have been read. With 54 words of the oldest packet read, `in_ready` stays 0. After the 55th word is read, `in_ready` returns to 1 within two cycles.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hp_mode | input | 1 | 1: vectors in half-pixel units; 0: full-pixel units |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Formatter accepts the input word this cycle |
| in_data | input | 16 | Header word, or vector value in bits 11:0 |
| in_ref | input | 1 | Reference-field bit for a vertical vector |
| out_ready | input | 1 | Consumer takes the output word this cycle |
| out_valid | output | 1 | Output word present |
| out_data | output | 16 | Packet word |
| out_last | output | 1 | Final word of the packet |

## Verification
The hardest state to reach from the ports is the one where both halves hold packets and the oldest packet is one word short of fully read. That is the only state in which an early release of a half would show. The bench fills both halves without reading and holds a third header on the input to show that the stall persists. It then drains exactly 54 words and samples `in_ready` before and after the final read. The formatting corners are covered by a table that includes the extreme 12-bit values, odd negative values, and reference bits set on horizontal inputs.

// File: rtl/mvfmt_pkg.sv
package mvfmt_pkg;

    typedef enum logic [1:0] {
        WR_WAIT_FREE = 2'd0,
        WR_TAKE_HDR  = 2'd1,
        WR_TAKE_VEC  = 2'd2
    } wr_state_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_SEND = 1'b1
    } rd_state_e;

    typedef enum logic {
        AX_HORIZ = 1'b0,
        AX_VERT  = 1'b1
    } mv_axis_e;

endpackage

// File: rtl/mvfmt_vecfmt.sv
module mvfmt_vecfmt
    import mvfmt_pkg::*;
#(
    parameter int VW         = 12,
    parameter int OW         = 16,
    parameter int LUMA_ORG   = 8,
    parameter int CHROMA_ORG = 4
) (
    input  logic [VW-1:0] vec,
    input  logic          ref_bit,
    input  mv_axis_e      axis,
    input  logic          hp_mode,
    output logic [OW-1:0] luma_word,
    output logic [OW-1:0] chroma_word
);

    logic [OW-1:0] v_ext;
    logic [OW-1:0] v_half;
    logic [OW-1:0] ch_base;
    logic [OW-1:0] luma_off;
    logic [OW-1:0] chroma_off;
    logic [OW-1:0] vert_word;

    // sign extension and arithmetic halving
    assign v_ext   = {{(OW-VW){vec[VW-1]}}, vec};
    assign v_half  = {v_ext[OW-1], v_ext[OW-1:1]};
    assign ch_base = {v_half[OW-1:1], v_half[0] | v_ext[0]};

    // origin offset doubles in half-pixel units
    assign luma_off   = hp_mode ? OW'(2 * LUMA_ORG)   : OW'(LUMA_ORG);
    assign chroma_off = hp_mode ? OW'(2 * CHROMA_ORG) : OW'(CHROMA_ORG);

    // magnitude shifted above a hole at bit 1 that carries the field bit
    assign vert_word = {v_half[OW-3:0], ref_bit, v_ext[0]};

    always_comb begin
        luma_word   = '0;
        chroma_word = '0;
        unique case (axis)
            AX_HORIZ: begin
                luma_word   = v_ext + luma_off;
                chroma_word = ch_base + chroma_off;
            end
            AX_VERT: begin
                luma_word   = vert_word;
                chroma_word = vert_word;
            end
            default: begin
                luma_word   = '0;
                chroma_word = '0;
            end
        endcase
    end

endmodule

// File: rtl/mvfmt_pingpong.sv
module mvfmt_pingpong
    import mvfmt_pkg::*;
#(
    parameter int OW    = 16,
    parameter int PKT_N = 55,
    parameter int REP_N = 2,
    localparam int AW   = $clog2(PKT_N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_half,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [OW-1:0] wr_data,
    input  logic          rep_en,
    input  logic [AW-1:0] rep_addr,
    input  logic [OW-1:0] rep_data,
    input  logic          commit,
    output logic [1:0]    full,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [OW-1:0] out_data,
    output logic          out_last
);

    logic [OW-1:0] rd_arr [2][PKT_N];
    logic [1:0]    full_q;
    rd_state_e     rd_state_q, rd_state_d;
    logic          rd_half_q;
    logic [AW-1:0] rd_idx_q;
    logic          rd_take;
    logic          rd_done;

    // storage cells: one word port plus one replicated-word port
    for (genvar w = 0; w < PKT_N; w++) begin : g_word
        logic hit_wr;
        logic hit_rep;
        assign hit_wr  = wr_en && (wr_addr == AW'(w));
        assign hit_rep = rep_en && (AW'(w) >= rep_addr) &&
                         ({1'b0, AW'(w)} < ({1'b0, rep_addr} + (AW+1)'(REP_N)));
        for (genvar h = 0; h < 2; h++) begin : g_half
            logic [OW-1:0] cell_q;
            always_ff @(posedge clk) begin
                if ((wr_half == 1'(h)) && (hit_wr || hit_rep)) begin
                    cell_q <= hit_wr ? wr_data : rep_data;
                end
            end
            assign rd_arr[h][w] = cell_q;
        end
    end

    // reader state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_state_q <= RD_IDLE;
            rd_half_q  <= 1'b0;
            rd_idx_q   <= '0;
            full_q     <= 2'b00;
        end else begin
            rd_state_q <= rd_state_d;
            if (commit) begin
                full_q[wr_half] <= 1'b1;
            end
            if (rd_done) begin
                full_q[rd_half_q] <= 1'b0;
                rd_half_q         <= ~rd_half_q;
                rd_idx_q          <= '0;
            end else if (rd_take) begin
                rd_idx_q <= rd_idx_q + 1'b1;
            end
        end
    end

    // reader next state
    always_comb begin
        rd_state_d = rd_state_q;
        unique case (rd_state_q)
            RD_IDLE: if (full_q[rd_half_q]) rd_state_d = RD_SEND;
            RD_SEND: if (rd_done)           rd_state_d = RD_IDLE;
            default: rd_state_d = RD_IDLE;
        endcase
    end

    // reader outputs
    always_comb begin
        out_valid = 1'b0;
        out_last  = 1'b0;
        rd_take   = 1'b0;
        rd_done   = 1'b0;
        unique case (rd_state_q)
            RD_IDLE: begin
                out_valid = 1'b0;
            end
            RD_SEND: begin
                out_valid = 1'b1;
                out_last  = (rd_idx_q == AW'(PKT_N - 1));
                rd_take   = out_ready;
                rd_done   = out_ready && out_last;
            end
            default: begin
                out_valid = 1'b0;
            end
        endcase
    end

    assign out_data = rd_arr[rd_half_q][rd_idx_q];
    assign full     = full_q;

endmodule

// File: rtl/mvfmt_top.sv
module mvfmt_top
    import mvfmt_pkg::*;
#(
    parameter int VW              = 12,
    parameter int OW              = 16,
    parameter int HDR_N           = 7,
    parameter int LUMA_N          = 16,
    parameter int CHROMA_PER_LUMA = 2,
    parameter int LUMA_ORG        = 8,
    parameter int CHROMA_ORG      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hp_mode,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [OW-1:0] in_data,
    input  logic          in_ref,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [OW-1:0] out_data,
    output logic          out_last
);

    localparam int CHROMA_N = LUMA_N * CHROMA_PER_LUMA;
    localparam int PKT_N    = HDR_N + LUMA_N + CHROMA_N;
    localparam int AW       = $clog2(PKT_N);
    localparam int CNT_MAX  = (HDR_N > LUMA_N) ? HDR_N : LUMA_N;
    localparam int CW       = $clog2(CNT_MAX);

    wr_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          half_q;
    logic [1:0]    full;
    logic          accept;
    logic          hdr_last;
    logic          vec_last;

    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [OW-1:0] wr_data;
    logic          rep_en;
    logic [AW-1:0] rep_addr;
    logic          commit;

    mv_axis_e      axis;
    logic [OW-1:0] luma_word;
    logic [OW-1:0] chroma_word;

    assign accept   = in_valid && in_ready;
    assign hdr_last = (cnt_q == CW'(HDR_N - 1));
    assign vec_last = (cnt_q == CW'(LUMA_N - 1));
    assign axis     = cnt_q[0] ? AX_VERT : AX_HORIZ;

    mvfmt_vecfmt #(
        .VW         (VW),
        .OW         (OW),
        .LUMA_ORG   (LUMA_ORG),
        .CHROMA_ORG (CHROMA_ORG)
    ) u_vecfmt (
        .vec         (in_data[VW-1:0]),
        .ref_bit     (in_ref),
        .axis        (axis),
        .hp_mode     (hp_mode),
        .luma_word   (luma_word),
        .chroma_word (chroma_word)
    );

    mvfmt_pingpong #(
        .OW    (OW),
        .PKT_N (PKT_N),
        .REP_N (CHROMA_PER_LUMA)
    ) u_pingpong (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_half   (half_q),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rep_en    (rep_en),
        .rep_addr  (rep_addr),
        .rep_data  (chroma_word),
        .commit    (commit),
        .full      (full),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    // writer state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= WR_WAIT_FREE;
            cnt_q   <= '0;
            half_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                if ((state_q == WR_TAKE_HDR && hdr_last) ||
                    (state_q == WR_TAKE_VEC && vec_last)) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
            if (commit) begin
                half_q <= ~half_q;
            end
        end
    end

    // writer next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_WAIT_FREE: if (!full[half_q])         state_d = WR_TAKE_HDR;
            WR_TAKE_HDR:  if (accept && hdr_last)    state_d = WR_TAKE_VEC;
            WR_TAKE_VEC:  if (accept && vec_last)    state_d = WR_WAIT_FREE;
            default:      state_d = WR_WAIT_FREE;
        endcase
    end

    // writer outputs
    always_comb begin
        in_ready = 1'b0;
        wr_en    = 1'b0;
        wr_addr  = '0;
        wr_data  = in_data;
        rep_en   = 1'b0;
        rep_addr = '0;
        commit   = 1'b0;
        unique case (state_q)
            WR_WAIT_FREE: begin
                in_ready = 1'b0;
            end
            WR_TAKE_HDR: begin
                in_ready = 1'b1;
                wr_en    = accept;
                wr_addr  = AW'(cnt_q);
                wr_data  = in_data;
            end
            WR_TAKE_VEC: begin
                in_ready = 1'b1;
                wr_en    = accept;
                wr_addr  = AW'(HDR_N) + AW'(cnt_q);
                wr_data  = luma_word;
                rep_en   = accept;
                rep_addr = AW'(HDR_N + LUMA_N) + AW'(cnt_q) * AW'(CHROMA_PER_LUMA);
                commit   = accept && vec_last;
            end
            default: begin
                in_ready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mvfmt_chk.sv
module mvfmt_chk #(
    parameter int OW              = 16,
    parameter int HDR_N           = 7,
    parameter int LUMA_N          = 16,
    parameter int CHROMA_PER_LUMA = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_ready,
    input logic          out_valid,
    input logic [OW-1:0] out_data,
    input logic          out_last
);

    localparam int IN_N  = HDR_N + LUMA_N;
    localparam int PKT_N = IN_N + LUMA_N * CHROMA_PER_LUMA;
    localparam int IW    = $clog2(IN_N);
    localparam int OCW   = $clog2(PKT_N);

    logic [IW-1:0]  icnt_q;
    logic [OCW-1:0] ocnt_q;
    logic [1:0]     held_q;
    logic           pkt_in;
    logic           pkt_out;

    assign pkt_in  = in_valid && in_ready && (icnt_q == IW'(IN_N - 1));
    assign pkt_out = out_valid && out_ready && (ocnt_q == OCW'(PKT_N - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            icnt_q <= '0;
            ocnt_q <= '0;
            held_q <= 2'd0;
        end else begin
            if (in_valid && in_ready) begin
                icnt_q <= pkt_in ? '0 : icnt_q + 1'b1;
            end
            if (out_valid && out_ready) begin
                ocnt_q <= pkt_out ? '0 : ocnt_q + 1'b1;
            end
            unique case ({pkt_in, pkt_out})
                2'b10:   held_q <= held_q + 2'd1;
                2'b01:   held_q <= held_q - 2'd1;
                default: held_q <= held_q;
            endcase
        end
    end

    assert_empty_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q == 2'd0) |-> !out_valid);

    assert_last_marks_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_last == (ocnt_q == OCW'(PKT_N - 1))));

    assert_stall_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q == 2'd2) |-> !in_ready);

    assert_bounded_store_R8: assert property (@(posedge clk) disable iff (!rst_n)
        held_q <= 2'd2);

    assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

endmodule

bind mvfmt_top mvfmt_chk #(
    .OW              (OW),
    .HDR_N           (HDR_N),
    .LUMA_N          (LUMA_N),
    .CHROMA_PER_LUMA (CHROMA_PER_LUMA)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/sim_mvfmt_top.sv
`timescale 1ns/1ps
module sim_mvfmt_top;

    localparam int PKT = 55;

    // luma table for packet 0 (half-pixel mode): value, ref, luma word, chroma word
    localparam int TV_V [16] = '{0, 5, -1, -3, 7, 4, -16, -1, 100, 0, -33, 2047, -2048, -2048, 6, 1};
    localparam int TV_R [16] = '{1, 1, 1, 0, 0, 1, 1, 1, 1, 1, 0, 0, 1, 1, 0, 0};
    localparam int TV_L [16] = '{16, 11, 15, -7, 23, 10, 0, -1, 116, 2, -17, 4093, -2032, -4094, 22, 1};
    localparam int TV_C [16] = '{8, 11, 7, -7, 11, 10, 0, -1, 58, 2, -9, 4093, -1016, -4094, 11, 1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hp_mode = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_data = '0;
    logic        in_ref = 1'b0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [15:0] out_data;
    logic        out_last;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int          pv  [3][16];
    bit          pr  [3][16];
    bit          php [3];
    logic [15:0] exp_pkt [3][PKT];

    always #4 clk = ~clk;

    mvfmt_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .hp_mode   (hp_mode),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_ref    (in_ref),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic logic [15:0] f_lh(int v, bit hp);
        return 16'(v + (hp ? 16 : 8));
    endfunction

    function automatic logic [15:0] f_ch(int v, bit hp);
        return 16'(((v >>> 1) | (v & 1)) + (hp ? 8 : 4));
    endfunction

    function automatic logic [15:0] f_vt(int v, bit r);
        return 16'(((v >>> 1) * 4) + (r ? 2 : 0) + (v & 1));
    endfunction

    function automatic string tag(int i);
        if (i < 7) return "R2";
        if (i < 23) return (((i - 7) % 2) == 0) ? "R3" : "R4";
        return ((((i - 23) / 2) % 2) == 0) ? "R5" : "R6";
    endfunction

    task automatic build(input int p);
        for (int h = 0; h < 7; h++) exp_pkt[p][h] = 16'('hA000 + p * 256 + h);
        for (int k = 0; k < 16; k++) begin
            logic [15:0] lw, cw;
            if (p == 0) begin
                lw = 16'(TV_L[k]);
                cw = 16'(TV_C[k]);
            end else if ((k % 2) == 0) begin
                lw = f_lh(pv[p][k], php[p]);
                cw = f_ch(pv[p][k], php[p]);
            end else begin
                lw = f_vt(pv[p][k], pr[p][k]);
                cw = lw;
            end
            exp_pkt[p][7 + k]      = lw;
            exp_pkt[p][23 + 2 * k] = cw;
            exp_pkt[p][24 + 2 * k] = cw;
        end
    endtask

    task automatic send_word(input logic [15:0] d, input logic r);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_ref   = r;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
    endtask

    task automatic send_pkt(input int p);
        hp_mode = php[p];
        for (int h = 0; h < 7; h++) send_word(16'('hA000 + p * 256 + h), 1'b0);
        for (int k = 0; k < 16; k++) send_word(16'(pv[p][k]), pr[p][k]);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic recv_word(output logic [15:0] d, output logic l);
        @(negedge clk);
        out_ready = 1'b1;
        while (!out_valid) @(negedge clk);
        d = out_data;
        l = out_last;
        @(posedge clk);
        #1 out_ready = 1'b0;
    endtask

    task automatic read_pkt(input int p, input int first, input int count);
        for (int i = first; i < first + count; i++) begin
            logic [15:0] d;
            logic        l;
            recv_word(d, l);
            chk(d == exp_pkt[p][i], tag(i), $sformatf("pkt%0d word%0d", p, i), d, exp_pkt[p][i]);
            chk(l == (i == PKT - 1), "R2", $sformatf("pkt%0d last flag at word%0d", p, i),
                16'(l), 16'(i == PKT - 1));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual=%h expected=%h", 16'h0, 16'h1);
            report();
            $finish;
        end
    end

    initial begin
        logic [15:0] held;

        // packet contents
        for (int k = 0; k < 16; k++) begin
            pv[0][k] = TV_V[k];
            pr[0][k] = TV_R[k] != 0;
            pv[1][k] = ((k * 173) % 700) - 350;
            pr[1][k] = (k % 3) != 1;      // refs also set on horizontals: no effect (R3)
            pv[2][k] = 2047 - k * 271;
            pr[2][k] = (k % 2) == 0;
        end
        php[0] = 1'b1;
        php[1] = 1'b0;
        php[2] = 1'b1;
        for (int p = 0; p < 3; p++) build(p);

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", 16'(out_valid), 16'h0);
        chk(in_ready == 1'b0, "R1", "in_ready in reset", 16'(in_ready), 16'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 16'(in_ready), 16'h1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 16'(out_valid), 16'h0);

        // R7: two packets stored with no reads
        send_pkt(0);
        send_pkt(1);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 16'hA200;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if ((c % 5) == 4)
                chk(in_ready == 1'b0, "R7", "stall with both halves full", 16'(in_ready), 16'h0);
        end
        in_valid = 1'b0;

        // R8: oldest packet read except one word
        read_pkt(0, 0, PKT - 1);
        @(negedge clk);
        chk(in_ready == 1'b0, "R8", "half held with one word unread", 16'(in_ready), 16'h0);
        read_pkt(0, PKT - 1, 1);
        repeat (2) @(negedge clk);
        chk(in_ready == 1'b1, "R8", "half released after last read", 16'(in_ready), 16'h1);

        // third packet into the released half
        send_pkt(2);

        // R9: output held under backpressure
        @(negedge clk);
        out_ready = 1'b0;
        while (!out_valid) @(negedge clk);
        held = out_data;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b1, "R9", "valid held", 16'(out_valid), 16'h1);
        chk(out_data == held, "R9", "data held", out_data, held);

        read_pkt(1, 0, PKT);
        read_pkt(2, 0, PKT);

        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid with nothing stored", 16'(out_valid), 16'h0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule